// File: doc/BRIEF.md
# Seeded Word-Wide CRC Checksum Engine

This block computes a 32-bit CRC-style checksum over a byte stream. Each job begins with a start pulse, which selects a starting seed, a total length in bytes and a mode. The engine then takes bytes through a valid/ready handshake until a byte marked as last arrives. It packs every four bytes into a little-endian word and XORs that word into the whole state. It then applies 32 unreflected shift-and-reduce steps, all in one clock. There is no reflection and no final inversion, so the state after the last word is the result.

In checksum mode every word enters the calculation. In verify mode the image carries its own checksum. The last eight bytes are left out of the calculation. Of those eight, the first four are ignored and the final four hold the expected value. The engine reports a match when the computed state equals that stored value. Two seed presets, one for boot headers and one for code sections, can be picked without software supplying the value. A length or termination error suppresses the match output.

Top module: `crc_seed_engine`

## Requirements
- R1: After reset, crc_out is 0 and done, match, len_err and in_ready are all low.
- R2: On start the state loads the seed chosen by seed_sel: code 1 gives 0x31113111, code 2 gives 0x55AA55AA, and codes 0 and 3 give seed_in. Different seeds over the same data give different checksums.
- R3: Bytes are packed little-endian: the first byte of a group is bits 7:0 and the fourth is bits 31:24. Each word is XORed into the state. The state is then shifted left 32 times, and after each shift it is XORed with 0x04C11DB7 whenever the bit shifted out of bit 31 was 1. In checksum mode crc_out is the final state.
- R4: in_ready is high from the cycle after start until the byte marked last has been accepted, and low otherwise. A byte is consumed only when in_valid and in_ready are both high.
- R5: done rises in the cycle after the last byte is accepted, is low before that, and holds together with crc_out until the next start.
- R6: In verify mode crc_out covers bytes 0 to length-9. Bytes length-8 to length-5 affect neither crc_out nor match. Bytes length-4 to length-1 form a little-endian stored word, and match is 1 exactly when it equals crc_out.
- R7: len_err is raised at done when the length is not a multiple of four, is zero, is below 8 in verify mode, or differs from the number of bytes received up to the last marker. len_err forces match low.
- R8: A start pulse clears done, match, len_err and crc_out in the next cycle.
- R9: In checksum mode match stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job; latches seed, length and mode |
| seed_sel | input | 2 | Seed choice: 1 header preset, 2 section preset, 0/3 seed_in |
| seed_in | input | 32 | Software-supplied seed |
| total_len | input | LEN_W | Job length in bytes |
| verify_en | input | 1 | 1 = verify mode, 0 = checksum mode |
| in_valid | input | 1 | Byte on in_data is valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the job |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| crc_out | output | 32 | Final checksum |
| done | output | 1 | Job finished; outputs valid |
| match | output | 1 | Verify mode: stored value equals computed value |
| len_err | output | 1 | Length or termination error |

## Verification
The assertions assume that start is not raised in the same cycle as the accepted last byte. They also assume that once a job is running, start comes only as a single-cycle pulse. The bench drives start only while the engine is idle or after done, apart from one deliberate restart after a finished job. The bench presents bytes only after in_ready has risen. It places in_last on exactly one byte per job, with random idle gaps between bytes so that stalls are covered.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY     = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] HDR_SEED     = 32'h3111_3111;
  localparam logic [CRC_W-1:0] SECTION_SEED = 32'h55AA_55AA;

  typedef enum logic [1:0] {
    SEED_USER     = 2'd0,
    SEED_HEADER   = 2'd1,
    SEED_SECTION  = 2'd2,
    SEED_USER_ALT = 2'd3
  } seed_src_e;
endpackage

// File: rtl/crc_fold.sv
module crc_fold #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] POLY = 32'h04C1_1DB7
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] word_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] stage [0:W];

  assign stage[0] = state_i ^ word_i;

  for (genvar g = 0; g < W; g++) begin : g_step
    assign stage[g+1] = stage[g][W-1] ? ({stage[g][W-2:0], 1'b0} ^ POLY)
                                      :  {stage[g][W-2:0], 1'b0};
  end

  assign state_o = stage[W];
endmodule

// File: rtl/crc_byte_packer.sv
module crc_byte_packer #(
  parameter int unsigned LEN_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clear,
  input  logic           byte_v,
  input  logic [7:0]     byte_d,
  output logic           word_v,
  output logic [31:0]    word,
  output logic [LEN_W:0] byte_cnt
);
  logic [23:0] hold_q;
  logic [1:0]  lane;

  assign lane   = byte_cnt[1:0];
  assign word_v = byte_v && (lane == 2'd3);
  assign word   = {byte_d, hold_q};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      hold_q   <= '0;
      byte_cnt <= '0;
    end else if (byte_v) begin
      byte_cnt <= byte_cnt + 1'b1;
      case (lane)
        2'd0: hold_q[7:0]   <= byte_d;
        2'd1: hold_q[15:8]  <= byte_d;
        2'd2: hold_q[23:16] <= byte_d;
        default: hold_q     <= hold_q;
      endcase
    end
  end
endmodule

// File: rtl/crc_window.sv
module crc_window #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             verify,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W:0]   byte_cnt,
  output logic             is_calc,
  output logic             is_stored
);
  localparam int unsigned IW = LEN_W + 2;

  logic [IW-1:0] widx;
  logic [IW-1:0] nwords;

  assign widx   = IW'(byte_cnt[LEN_W:2]);
  assign nwords = IW'(len[LEN_W-1:2]);

  assign is_calc   = !verify || ((widx + IW'(2)) < nwords);
  assign is_stored = verify && ((widx + IW'(1)) == nwords);
endmodule

// File: rtl/crc_seed_engine.sv
module crc_seed_engine
  import crc_pkg::*;
#(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       seed_sel,
  input  logic [31:0]      seed_in,
  input  logic [LEN_W-1:0] total_len,
  input  logic             verify_en,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  output logic             in_ready,
  output logic [31:0]      crc_out,
  output logic             done,
  output logic             match,
  output logic             len_err
);
  logic             busy_q;
  logic [31:0]      state_q, stored_q, crc_q;
  logic             done_q, match_q, err_q;
  logic [LEN_W-1:0] len_q;
  logic             verify_q;

  logic             acc;
  logic             word_v;
  logic [31:0]      word;
  logic [LEN_W:0]   byte_cnt;
  logic             is_calc, is_stored;
  logic [31:0]      fold_out;
  logic [31:0]      seed_pick;
  logic [31:0]      final_crc, final_stored;
  logic             bad_len;
  seed_src_e        seed_src;

  assign seed_src = seed_src_e'(seed_sel);
  assign acc      = in_valid && busy_q && !start;

  always_comb begin
    case (seed_src)
      SEED_HEADER:  seed_pick = HDR_SEED;
      SEED_SECTION: seed_pick = SECTION_SEED;
      default:      seed_pick = seed_in;
    endcase
  end

  crc_byte_packer #(.LEN_W(LEN_W)) u_pack (
    .clk(clk), .rst(rst), .clear(start),
    .byte_v(acc), .byte_d(in_data),
    .word_v(word_v), .word(word), .byte_cnt(byte_cnt)
  );

  crc_window #(.LEN_W(LEN_W)) u_win (
    .verify(verify_q), .len(len_q), .byte_cnt(byte_cnt),
    .is_calc(is_calc), .is_stored(is_stored)
  );

  crc_fold #(.W(CRC_W), .POLY(CRC_POLY)) u_fold (
    .state_i(state_q), .word_i(word), .state_o(fold_out)
  );

  assign final_crc    = (word_v && is_calc)   ? fold_out : state_q;
  assign final_stored = (word_v && is_stored) ? word     : stored_q;
  assign bad_len = (len_q[1:0] != 2'd0) || (len_q == '0) ||
                   (verify_q && (len_q < LEN_W'(8))) ||
                   ((byte_cnt + 1'b1) != {1'b0, len_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      state_q  <= '0;
      stored_q <= '0;
      crc_q    <= '0;
      done_q   <= 1'b0;
      match_q  <= 1'b0;
      err_q    <= 1'b0;
      len_q    <= '0;
      verify_q <= 1'b0;
    end else if (start) begin
      busy_q   <= 1'b1;
      state_q  <= seed_pick;
      stored_q <= '0;
      crc_q    <= '0;
      done_q   <= 1'b0;
      match_q  <= 1'b0;
      err_q    <= 1'b0;
      len_q    <= total_len;
      verify_q <= verify_en;
    end else if (acc) begin
      if (word_v && is_calc)   state_q  <= fold_out;
      if (word_v && is_stored) stored_q <= word;
      if (in_last) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        crc_q   <= final_crc;
        err_q   <= bad_len;
        match_q <= verify_q && !bad_len && (final_crc == final_stored);
      end
    end
  end

  assign in_ready = busy_q;
  assign crc_out  = crc_q;
  assign done     = done_q;
  assign match    = match_q;
  assign len_err  = err_q;

  // R2
  hdr_seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start && seed_sel == 2'd1) |=> (state_q == 32'h3111_3111));
  // R2
  sec_seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (start && seed_sel == 2'd2) |=> (state_q == 32'h55AA_55AA));
  // R4
  ready_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> in_ready);
  // R5
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last && !start) |=> (done && !in_ready));
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(crc_out)));
  // R8
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (!done && !match && !len_err && crc_out == 32'h0));
  // R7
  err_blocks_match_chk: assert property (@(posedge clk) disable iff (rst)
    len_err |-> !match);
  // R9
  match_only_verify_chk: assert property (@(posedge clk) disable iff (rst)
    match |-> verify_q);
endmodule

// File: tb/sim_crc_seed_engine.sv
module sim_crc_seed_engine;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] seed_sel = 2'd0;
  logic [31:0] seed_in = 32'h0;
  logic [LEN_W-1:0] total_len = '0;
  logic verify_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h0;
  logic in_last = 1'b0;
  logic in_ready;
  logic [31:0] crc_out;
  logic done, match, len_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] img [0:255];

  always #2 clk = ~clk;

  crc_seed_engine #(.LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .seed_sel(seed_sel), .seed_in(seed_in),
    .total_len(total_len), .verify_en(verify_en), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .crc_out(crc_out), .done(done), .match(match), .len_err(len_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] seed_of(input logic [1:0] sel, input logic [31:0] user);
    if (sel == 2'd1) return 32'h3111_3111;
    if (sel == 2'd2) return 32'h55AA_55AA;
    return user;
  endfunction

  function automatic logic [31:0] mdl(input logic [31:0] seed, input int nbytes);
    logic [31:0] s = seed;
    for (int i = 0; i + 3 < nbytes; i += 4) begin
      s ^= {img[i+3], img[i+2], img[i+1], img[i]};
      for (int k = 0; k < 32; k++) begin
        if (s[31]) s = {s[30:0], 1'b0} ^ 32'h04C1_1DB7;
        else       s = {s[30:0], 1'b0};
      end
    end
    return s;
  endfunction

  task automatic fill_rand(input int n);
    for (int i = 0; i < n; i++) img[i] = 8'($urandom);
  endtask

  task automatic place_stored(input int len, input logic [31:0] v);
    img[len-4] = v[7:0];   img[len-3] = v[15:8];
    img[len-2] = v[23:16]; img[len-1] = v[31:24];
  endtask

  task automatic run_job(input logic [1:0] sel, input logic [31:0] sd, input int lenf,
                         input int nsend, input bit ver, input int gapmax);
    @(negedge clk);
    seed_sel = sel; seed_in = sd; total_len = LEN_W'(lenf); verify_en = ver;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(in_ready == 1'b1, "R4", "ready after start", 32'(in_ready), 32'h1);
    for (int i = 0; i < nsend; i++) begin
      repeat ($urandom_range(0, gapmax)) @(negedge clk);
      in_valid = 1'b1; in_data = img[i]; in_last = (i == nsend - 1);
      if (i == nsend - 1)
        chk(done == 1'b0, "R5", "done low before last", 32'(done), 32'h0);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
    end
    chk(done == 1'b1, "R5", "done after last", 32'(done), 32'h1);
    chk(in_ready == 1'b0, "R4", "ready low after last", 32'(in_ready), 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] c_hdr, c_ref, sd, exp_c;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(crc_out == 32'h0, "R1", "crc reset", crc_out, 32'h0);
    chk(done == 1'b0, "R1", "done reset", 32'(done), 32'h0);
    chk(match == 1'b0 && len_err == 1'b0, "R1", "flags reset", {30'h0, match, len_err}, 32'h0);
    chk(in_ready == 1'b0, "R1", "ready reset", 32'(in_ready), 32'h0);

    // R3 checksum mode, header preset
    fill_rand(16);
    run_job(2'd1, 32'h0, 16, 16, 1'b0, 2);
    exp_c = mdl(32'h3111_3111, 16);
    chk(crc_out == exp_c, "R3", "header preset checksum", crc_out, exp_c);
    chk(match == 1'b0, "R9", "no match in checksum mode", 32'(match), 32'h0);
    chk(len_err == 1'b0, "R7", "aligned length ok", 32'(len_err), 32'h0);
    c_hdr = crc_out;

    // R2 section preset on same data, must differ
    run_job(2'd2, 32'h0, 16, 16, 1'b0, 0);
    exp_c = mdl(32'h55AA_55AA, 16);
    chk(crc_out == exp_c, "R2", "section preset checksum", crc_out, exp_c);
    chk(crc_out != c_hdr, "R2", "seeds differ", crc_out, ~c_hdr);

    // R2 user seed on codes 0 and 3
    sd = $urandom;
    run_job(2'd0, sd, 16, 16, 1'b0, 1);
    exp_c = mdl(sd, 16);
    chk(crc_out == exp_c, "R2", "user seed code0", crc_out, exp_c);
    run_job(2'd3, sd, 16, 16, 1'b0, 1);
    chk(crc_out == exp_c, "R2", "user seed code3", crc_out, exp_c);

    // R6 verify with correct stored value
    fill_rand(32);
    c_ref = mdl(32'h55AA_55AA, 24);
    place_stored(32, c_ref);
    run_job(2'd2, 32'h0, 32, 32, 1'b1, 2);
    chk(crc_out == c_ref, "R6", "verify crc covers head", crc_out, c_ref);
    chk(match == 1'b1, "R6", "verify match", 32'(match), 32'h1);

    // R5 result holds while junk is presented
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 8'($urandom); in_last = k[0];
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
    chk(crc_out == c_ref && done == 1'b1, "R5", "result held", crc_out, c_ref);
    chk(in_ready == 1'b0, "R4", "ready stays low idle", 32'(in_ready), 32'h0);

    // R6 skipped bytes have no effect
    for (int i = 24; i < 28; i++) img[i] = ~img[i];
    run_job(2'd2, 32'h0, 32, 32, 1'b1, 1);
    chk(crc_out == c_ref, "R6", "skip bytes ignored crc", crc_out, c_ref);
    chk(match == 1'b1, "R6", "skip bytes ignored match", 32'(match), 32'h1);

    // R8 start clears previous result
    @(negedge clk);
    seed_sel = 2'd2; total_len = LEN_W'(32); verify_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && match == 1'b0, "R8", "start clears done/match", {30'h0, done, match}, 32'h0);
    chk(crc_out == 32'h0, "R8", "start clears crc", crc_out, 32'h0);
    for (int i = 0; i < 32; i++) begin
      in_valid = 1'b1; in_data = img[i]; in_last = (i == 31);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    chk(match == 1'b1, "R6", "match after restart", 32'(match), 32'h1);

    // R6 corrupted stored value
    img[31] = img[31] ^ 8'h01;
    run_job(2'd2, 32'h0, 32, 32, 1'b1, 0);
    chk(match == 1'b0, "R6", "corrupt stored mismatch", 32'(match), 32'h0);

    // R7 length errors
    fill_rand(16);
    run_job(2'd1, 32'h0, 10, 10, 1'b0, 0);
    chk(len_err == 1'b1, "R7", "misaligned length", 32'(len_err), 32'h1);
    c_ref = mdl(32'h3111_3111, 8);
    place_stored(16, c_ref);
    run_job(2'd1, 32'h0, 16, 12, 1'b1, 0);
    chk(len_err == 1'b1 && match == 1'b0, "R7", "count mismatch", {30'h0, len_err, match}, 32'h2);
    run_job(2'd1, 32'h0, 4, 4, 1'b1, 0);
    chk(len_err == 1'b1 && match == 1'b0, "R7", "verify too short", {30'h0, len_err, match}, 32'h2);
    run_job(2'd1, 32'h0, 16, 16, 1'b1, 0);
    chk(len_err == 1'b0 && match == 1'b1, "R6", "min verify ok", {30'h0, len_err, match}, 32'h1);

    // random jobs
    for (int it = 0; it < 24; it++) begin
      int len = 4 * $urandom_range(2, 16);
      logic [1:0] sel = 2'($urandom);
      bit ver = 1'($urandom);
      bit good = 1'($urandom);
      sd = $urandom;
      fill_rand(len);
      if (ver) begin
        c_ref = mdl(seed_of(sel, sd), len - 8);
        place_stored(len, good ? c_ref : ~c_ref);
      end else begin
        c_ref = mdl(seed_of(sel, sd), len);
      end
      run_job(sel, sd, len, len, ver, 3);
      chk(crc_out == c_ref, "R3", "random crc", crc_out, c_ref);
      chk(match == (ver && good), "R6", "random match", 32'(match), 32'(ver && good));
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule